// File: doc/BRIEF.md
# Black-Level Offset Feedback Controller

This block keeps the black level of a line-scanned image sensor at a programmed clamp value. Each line carries an optical-black pulse. The controller detects the pulse edge, averages eight ADC samples that fall in a fixed window after it, and compares the mean with the clamp target. Once per line it then issues a signed correction word for the offset current DAC that follows it. The DAC, the hold capacitors and the amplifiers are outside the block.

When the amplifier gain changes, the loop enters a catch-up mode in which the correction is multiplied by a selectable power of two. The loop leaves catch-up only after the black-level error has stayed within 64 LSB for a selectable number of consecutive lines. A register run bit acts as the reset mode. When the bit is released, a fixed-length offset calibration phase starts, and the black-level loop stays frozen for the whole of that phase.

Top module: `blc_loop`

## Requirements
- R1: The clamp target is 56 + 8 × `clamp_code` LSB (5-bit code, 56 to 304). In normal mode each update sets `corr_out` to the target minus the truncated mean of the window samples, as a two's-complement value.
- R2: The first rising clock edge that samples the OB level active after it was inactive is edge 0. The ADC codes sampled at edges 5 through 12 form the mean, and codes at every other edge have no effect.
- R3: The active OB level is high when `ob_invert` is 0 and low when `ob_invert` is 1.
- R4: Per detected edge, `corr_out` changes and `corr_valid` is high for exactly one cycle, starting with the clock edge after edge 12. `corr_out` holds its value between updates. An OB edge that arrives while a window is open is ignored.
- R5: A one-cycle `gain_change` pulse while running sets `boost_active` from the next cycle. In catch-up mode the error is shifted left by `boost_sel` + 2, which gives ×4, ×8, ×16 or ×32 for `boost_sel` = 0..3.
- R6: While catch-up mode is active, an error magnitude above 64 keeps the mode on. The mode ends after 2^`hold_sel` consecutive updates with magnitude at most 64, so the hold is 1, 2, 4 or 8 lines. Each update uses the mode that was in force before that update.
- R7: An update with error magnitude above 64 during the hold restarts the hold count from its full value.
- R8: A rising edge of `loop_run` makes `cal_busy` high for exactly 40000 cycles, starting one cycle later.
- R9: While `cal_busy` is high, OB edges are ignored and no update occurs.
- R10: While `rst_n` is low, or `loop_run` is sampled low, `corr_out` is 0 and `corr_valid`, `boost_active` and `cal_busy` are low from the next cycle on. In that state `gain_change` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_run | input | 1 | Register run bit; low selects reset mode |
| ob_pulse | input | 1 | Optical-black line pulse |
| ob_invert | input | 1 | OB polarity select |
| adc_code | input | 12 | ADC output code |
| gain_change | input | 1 | One-cycle strobe on a gain setting change |
| clamp_code | input | 5 | Clamp target code |
| boost_sel | input | 2 | Catch-up multiplier select |
| hold_sel | input | 2 | Catch-up exit hold select (lines) |
| corr_out | output | 18 | Signed DAC correction |
| corr_valid | output | 1 | One-cycle update strobe |
| boost_active | output | 1 | Catch-up mode indicator |
| cal_busy | output | 1 | Offset calibration in progress |

## Verification
The assertions assume that every input is synchronous to `clk` and has a known value after reset. They also assume that `gain_change` is a single-cycle strobe. The stimulus changes inputs only on falling clock edges and holds each OB pulse active for three cycles. Polarity changes are made only together with the idle pulse level, so that the change itself never forms an edge. `loop_run` stays high through the whole calibration phase and drops only between lines, which lets the calibration-length property observe the natural end of the phase.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_BOOST  = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/blc_ob_window.sv
module blc_ob_window #(
  parameter int DATA_W    = 12,
  parameter int WIN_START = 5,
  parameter int WIN_LEN   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ob_act,
  input  logic [DATA_W-1:0] adc_code,
  output logic              avg_valid,
  output logic [DATA_W-1:0] avg
);
  localparam int WIN_END = WIN_START + WIN_LEN - 1;
  localparam int CNT_W   = $clog2(WIN_END + 1);
  localparam int AVG_SH  = $clog2(WIN_LEN);
  localparam int ACC_W   = DATA_W + $clog2(WIN_LEN + 1);

  logic             ob_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_base, acc_sum;
  logic [DATA_W-1:0] avg_calc;
  logic edge_det, open, in_win, last;

  assign edge_det = ob_act & ~ob_q;
  assign open     = (cnt_q != '0);
  assign in_win   = (cnt_q >= CNT_W'(WIN_START)) && (cnt_q <= CNT_W'(WIN_END));
  assign last     = (cnt_q == CNT_W'(WIN_END));
  assign acc_base = (cnt_q == CNT_W'(WIN_START)) ? '0 : acc_q;
  assign acc_sum  = acc_base + ACC_W'(adc_code);

  generate
    if ((1 << AVG_SH) == WIN_LEN) begin : g_shift_avg
      assign avg_calc = DATA_W'(acc_sum >> AVG_SH);
    end else begin : g_div_avg
      assign avg_calc = DATA_W'(acc_sum / ACC_W'(WIN_LEN));
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)                cnt_d = '0;
    else if (!open && edge_det) cnt_d = CNT_W'(1);
    else if (open && last)      cnt_d = '0;
    else if (open)              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_q      <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      avg_valid <= 1'b0;
      avg       <= '0;
    end else begin
      ob_q      <= ob_act;
      cnt_q     <= cnt_d;
      avg_valid <= enable & last;
      if (enable && in_win) acc_q <= acc_sum;
      if (enable && last)   avg   <= avg_calc;
    end
  end
endmodule

// File: rtl/blc_boost.sv
module blc_boost
  import blc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gain_change,
  input  logic             upd,
  input  logic             big_err,
  input  logic [SEL_W-1:0] hold_sel,
  output loop_mode_e       mode
);
  localparam int HOLD_MAX = 1 << ((1 << SEL_W) - 1);
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  loop_mode_e        mode_d;
  logic [HOLD_W-1:0] hold_q, hold_d, hold_load;

  assign hold_load = HOLD_W'(1) << hold_sel;

  always_comb begin
    mode_d = mode;
    hold_d = hold_q;
    if (!run) begin
      mode_d = MODE_NORMAL;
      hold_d = '0;
    end else if (gain_change) begin
      mode_d = MODE_BOOST;
      hold_d = hold_load;
    end else if (upd && mode == MODE_BOOST) begin
      if (big_err) begin
        hold_d = hold_load;
      end else if (hold_q <= HOLD_W'(1)) begin
        mode_d = MODE_NORMAL;
        hold_d = '0;
      end else begin
        hold_d = hold_q - HOLD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_NORMAL;
      hold_q <= '0;
    end else begin
      mode   <= mode_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/blc_cal_timer.sv
module blc_cal_timer #(
  parameter int CAL_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic busy
);
  localparam int CW = $clog2(CAL_CYCLES + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (!run_q)  cnt_d = CW'(CAL_CYCLES);
    else if (busy)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/blc_loop.sv
module blc_loop
  import blc_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int CLAMP_W       = 5,
  parameter int SEL_W         = 2,
  parameter int WIN_START     = 5,
  parameter int WIN_LEN       = 8,
  parameter int ERR_LIMIT     = 64,
  parameter int CLAMP_BASE    = 56,
  parameter int CLAMP_STEP    = 8,
  parameter int BOOST_MIN_LOG = 2,
  parameter int CAL_CYCLES    = 40000,
  parameter int CORR_W        = DATA_W + 1 + BOOST_MIN_LOG + (1 << SEL_W) - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     loop_run,
  input  logic                     ob_pulse,
  input  logic                     ob_invert,
  input  logic [DATA_W-1:0]        adc_code,
  input  logic                     gain_change,
  input  logic [CLAMP_W-1:0]       clamp_code,
  input  logic [SEL_W-1:0]         boost_sel,
  input  logic [SEL_W-1:0]         hold_sel,
  output logic signed [CORR_W-1:0] corr_out,
  output logic                     corr_valid,
  output logic                     boost_active,
  output logic                     cal_busy
);
  localparam int ERR_W     = DATA_W + 1;
  localparam int MAX_SHIFT = BOOST_MIN_LOG + (1 << SEL_W) - 1;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  logic                     avg_valid, big_err;
  logic [DATA_W-1:0]        avg;
  logic [ERR_W-1:0]         target, err_mag;
  logic signed [ERR_W-1:0]  err;
  logic signed [CORR_W-1:0] err_ext, corr_d;
  logic [SH_W-1:0]          sh;
  loop_mode_e               mode;

  blc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .run(loop_run), .busy(cal_busy)
  );

  blc_ob_window #(.DATA_W(DATA_W), .WIN_START(WIN_START), .WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .enable(loop_run & ~cal_busy),
    .ob_act(ob_pulse ^ ob_invert), .adc_code(adc_code),
    .avg_valid(avg_valid), .avg(avg)
  );

  blc_boost #(.SEL_W(SEL_W)) u_boost (
    .clk(clk), .rst_n(rst_n), .run(loop_run), .gain_change(gain_change),
    .upd(avg_valid), .big_err(big_err), .hold_sel(hold_sel), .mode(mode)
  );

  assign target  = ERR_W'(CLAMP_BASE) + ERR_W'(CLAMP_STEP) * ERR_W'(clamp_code);
  assign err     = $signed(target) - $signed({1'b0, avg});
  assign err_mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
  assign big_err = (err_mag > ERR_W'(ERR_LIMIT));
  assign err_ext = {{(CORR_W - ERR_W){err[ERR_W-1]}}, err};
  assign sh      = (mode == MODE_BOOST) ? (SH_W'(BOOST_MIN_LOG) + SH_W'(boost_sel)) : '0;
  assign boost_active = (mode == MODE_BOOST);

  always_comb begin
    corr_d = corr_out;
    if (!loop_run)      corr_d = '0;
    else if (avg_valid) corr_d = err_ext <<< sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_out   <= '0;
      corr_valid <= 1'b0;
    end else begin
      corr_out   <= corr_d;
      corr_valid <= loop_run & avg_valid;
    end
  end
endmodule

// File: rtl/blc_loop_checker.sv
module blc_loop_checker #(
  parameter int CAL_CYCLES = 40000,
  parameter int CORR_W     = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loop_run,
  input logic              gain_change,
  input logic [CORR_W-1:0] corr_out,
  input logic              corr_valid,
  input logic              boost_active,
  input logic              cal_busy
);
  localparam int BW = $clog2(CAL_CYCLES + 2);
  logic [BW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_len <= '0;
    else if (cal_busy) busy_len <= busy_len + BW'(1);
    else               busy_len <= '0;
  end

  a_r8_cal_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cal_busy) && $past(loop_run)) |-> (busy_len == BW'(CAL_CYCLES)));

  a_r8_cal_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (busy_len < BW'(CAL_CYCLES)));

  a_r9_no_update_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> !cal_busy);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> !corr_valid);

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_run) && !corr_valid) |-> $stable(corr_out));

  a_r5_enter_boost: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_run && gain_change) |=> boost_active);

  a_r6_exit_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_active) |-> (corr_valid || !$past(loop_run)));

  a_r10_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_run |=> (!boost_active && !cal_busy && !corr_valid && corr_out == '0));
endmodule

bind blc_loop blc_loop_checker #(.CAL_CYCLES(CAL_CYCLES), .CORR_W(CORR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_run(loop_run), .gain_change(gain_change),
  .corr_out(corr_out), .corr_valid(corr_valid), .boost_active(boost_active),
  .cal_busy(cal_busy)
);

// File: tb/blc_loop_bench.sv
module blc_loop_bench;
  logic clk = 1'b0;
  logic rst_n, loop_run, ob_pulse, ob_invert, gain_change;
  logic [11:0] adc_code;
  logic [4:0]  clamp_code;
  logic [1:0]  boost_sel, hold_sel;
  logic signed [17:0] corr_out;
  logic corr_valid, boost_active, cal_busy;

  int vec_cnt = 0;
  int bad_cnt = 0;
  int busy_cycles = 0;
  int exp_q[$];
  string tag_q[$];
  logic [11:0] samp [16];

  always #4 clk = ~clk;

  blc_loop u_blc_loop (
    .clk(clk), .rst_n(rst_n), .loop_run(loop_run), .ob_pulse(ob_pulse),
    .ob_invert(ob_invert), .adc_code(adc_code), .gain_change(gain_change),
    .clamp_code(clamp_code), .boost_sel(boost_sel), .hold_sel(hold_sel),
    .corr_out(corr_out), .corr_valid(corr_valid), .boost_active(boost_active),
    .cal_busy(cal_busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && corr_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected update", longint'(corr_out), 0);
      end else begin
        chk(longint'(corr_out) == longint'(exp_q[0]), tag_q[0],
            longint'(corr_out), longint'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  always @(negedge clk) if (cal_busy) busy_cycles++;

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  task automatic fill(input int first, input int step, input int outside);
    for (int k = 0; k < 16; k++)
      samp[k] = (k >= 5 && k <= 12) ? 12'(first + step * (k - 5)) : 12'(outside);
  endtask

  // driver: one line with an OB pulse; pushes the expected correction
  task automatic do_line(input int exp_val, input bit want, input string tag, input bit retrig);
    if (want) begin
      exp_q.push_back(exp_val);
      tag_q.push_back(tag);
    end
    ob_pulse = ~ob_invert;
    adc_code = samp[0];
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      adc_code = samp[k];
      if (k == 3 || (retrig && k == 9)) ob_pulse = ob_invert;
      if (retrig && k == 6) ob_pulse = ~ob_invert;
    end
    repeat (4) begin
      @(negedge clk);
      adc_code = 12'd0;
    end
  endtask

  task automatic strobe_gain();
    gain_change = 1'b1;
    @(negedge clk);
    gain_change = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; loop_run = 1'b0; ob_pulse = 1'b0; ob_invert = 1'b0;
    gain_change = 1'b0; adc_code = '0; clamp_code = 5'd9;
    boost_sel = 2'd1; hold_sel = 2'd1;
    repeat (3) @(negedge clk);
    chk(corr_out == 0 && !corr_valid && !boost_active && !cal_busy,
        "R10 reset state", longint'(corr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8/R9: calibration phase, OB line during it must not update
    loop_run = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b1, "R8 busy start", cal_busy, 1);
    fill(10, 0, 10);
    do_line(0, 1'b0, "", 1'b0);
    chk(corr_out == 0, "R9 no update in cal", longint'(corr_out), 0);
    while (cal_busy) @(negedge clk);
    chk(busy_cycles == 40000, "R8 busy length", busy_cycles, 40000);

    // R1/R2: normal updates, garbage outside window
    fill(100, 0, 4095); do_line(28, 1'b1, "R2 window", 1'b0);
    clamp_code = 5'd0; fill(200, 0, 0); do_line(-144, 1'b1, "R1 negative", 1'b0);
    clamp_code = 5'd31; fill(300, 1, 4095); do_line(1, 1'b1, "R1 truncated mean", 1'b0);

    // R3: inverted polarity
    @(negedge clk); ob_invert = 1'b1; ob_pulse = 1'b1; clamp_code = 5'd9;
    @(negedge clk);
    fill(120, 0, 0); do_line(8, 1'b1, "R3 inverted polarity", 1'b0);
    ob_invert = 1'b0; ob_pulse = 1'b0;
    @(negedge clk);

    // R4: second edge inside window ignored, output held
    fill(90, 0, 0); do_line(38, 1'b1, "R4 retrigger ignored", 1'b1);
    repeat (5) @(negedge clk);
    chk(corr_out == 38 && !corr_valid, "R4 hold", longint'(corr_out), 38);

    // R5/R6/R7: catch-up x8, hold 2 lines
    boost_sel = 2'd1; hold_sel = 2'd1;
    strobe_gain();
    chk(boost_active == 1'b1, "R5 enter boost", boost_active, 1);
    fill(0, 0, 0);   do_line(1024, 1'b1, "R5 boost x8", 1'b0);
    chk(boost_active == 1'b1, "R6 stays on big error", boost_active, 1);
    fill(118, 0, 0); do_line(80, 1'b1, "R6 boost small", 1'b0);
    chk(boost_active == 1'b1, "R6 hold pending", boost_active, 1);
    fill(58, 0, 0);  do_line(560, 1'b1, "R7 big error", 1'b0);
    fill(123, 0, 0); do_line(40, 1'b1, "R7 after reload", 1'b0);
    chk(boost_active == 1'b1, "R7 hold reloaded", boost_active, 1);
    fill(123, 0, 0); do_line(40, 1'b1, "R6 last boost line", 1'b0);
    chk(boost_active == 1'b0, "R6 exit", boost_active, 0);
    fill(123, 0, 0); do_line(5, 1'b1, "R6 normal after exit", 1'b0);

    // R6 boundary: 64 is small, 65 is big; x32, hold 1 line
    boost_sel = 2'd3; hold_sel = 2'd0;
    strobe_gain();
    fill(64, 0, 0);  do_line(2048, 1'b1, "R5 boost x32", 1'b0);
    chk(boost_active == 1'b0, "R6 error 64 exits", boost_active, 0);
    fill(63, 0, 0);  do_line(65, 1'b1, "R6 normal 65", 1'b0);
    strobe_gain();
    fill(63, 0, 0);  do_line(2080, 1'b1, "R6 error 65 boost", 1'b0);
    chk(boost_active == 1'b1, "R6 error 65 stays", boost_active, 1);

    // R10: reset mode
    loop_run = 1'b0;
    @(negedge clk);
    chk(corr_out == 0 && !boost_active && !cal_busy, "R10 run low clears",
        longint'(corr_out), 0);
    strobe_gain();
    @(negedge clk);
    chk(boost_active == 1'b0, "R10 gain ignored", boost_active, 0);
    fill(10, 0, 10); do_line(0, 1'b0, "", 1'b0);
    chk(corr_out == 0, "R10 no update", longint'(corr_out), 0);

    chk(exp_q.size() == 0, "R4 all updates seen", exp_q.size(), 0);
    report();
  end
endmodule